// File: doc/BRIEF.md
# Dual-Bit SPI Command Receiver

This block is the receive side of a serial command port, as found in board glue logic. It accepts command bytes from a host over a serial clock. One input picks either single-wire transfers or two-wire transfers. In two-wire mode, a second input pin carries the low bit of each pair; on the board this pin is a chip-select line put to a second use. The block runs in its own system clock domain. It synchronizes the serial pins and samples them on rising serial-clock edges, which it detects from the synchronized copies.

Each complete byte is presented on a parallel output together with a one-cycle valid strobe. Releasing chip select marks the end of a command and produces a one-cycle end pulse. Releasing chip select also throws away any byte that was only partly received. The block does not interpret commands and does not drive any reply.

Top module: `dspi_cmd_rx`

## Requirements
- R1: After reset, `byte_vld_o`, `cmd_end_o` and `byte_o` are all zero.
- R2: In single-wire mode (mode bit 0), the block shifts in one bit from `pri_i` on each rising edge of `sclk_i`, most significant bit first. Eight edges form one byte, and a command can carry several bytes back to back.
- R3: In two-wire mode (mode bit 1), the block takes two bits on each rising edge of `sclk_i`, so four edges form one byte.
- R4: In two-wire mode, `pri_i` supplies the upper bit of each pair and `sec_i` supplies the lower bit.
- R5: In two-wire mode, the pairs arrive as bits 7:6 first, then 5:4, then 3:2, and bits 1:0 last.
- R6: Releasing chip select (`csn_i` going high) clears the bit count and the partial byte. A partial byte is never reported, and the next command starts on a fresh byte.
- R7: The mode is taken from `dual_i` when chip select is asserted and is held for the whole command. Changes on `dual_i` during the command have no effect.
- R8: `byte_vld_o` is high for exactly one system clock cycle per received byte, and `byte_o` changes only when `byte_vld_o` is high.
- R9: Each release of chip select gives a `cmd_end_o` pulse exactly one cycle wide.
- R10: `byte_vld_o` rises on the third system clock edge after the rising serial-clock edge that completes a byte, and not before.
- R11: Serial clock edges seen while chip select is high are ignored and produce no bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| pri_i | input | 1 | Primary data line (upper bit in two-wire mode) |
| sec_i | input | 1 | Secondary data line (lower bit in two-wire mode) |
| dual_i | input | 1 | Transfer mode: 0 single-wire, 1 two-wire |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| cmd_end_o | output | 1 | One-cycle pulse when chip select is released |

## Verification
Every pin passes through two synchronizer flops before edge detection, and the outputs are registered once more. A result is therefore due on the third system clock edge after the pin change that causes it. The latency test drives the final serial edge on a falling system-clock edge. It checks that the strobe is still low two falling edges later and high on the third. All other tests send serial half-periods of several system cycles and wait out the pipeline before they compare. A monitor samples on falling edges and records every strobe and end pulse, so checks of strobe width and pulse count are independent of the exact cycle on which a pulse arrives.

// File: rtl/dspi_rx_pkg.sv
package dspi_rx_pkg;
    parameter int unsigned WORD_W = 8;
    localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              dual;
        logic [WORD_W-1:0] data;
        logic              vld;
        logic              done;
    } asm_state_t;

    typedef struct packed {
        logic sclk_prev;
        logic csn_prev;
    } edge_state_t;
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
    parameter int unsigned    N_BITS  = 5,
    parameter int unsigned    STAGES  = 2,
    parameter logic [N_BITS-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] async_i,
    output logic [N_BITS-1:0] sync_o
);
    logic [N_BITS-1:0] stg_d [STAGES];
    logic [N_BITS-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/dspi_edge.sv
module dspi_edge
    import dspi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic csn_s,
    output logic sclk_rise,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign cs_fall   = ~csn_s & st_q.csn_prev;
    assign cs_rise   = csn_s & ~st_q.csn_prev;
    assign cs_active = ~csn_s;
endmodule

// File: rtl/dspi_assembler.sv
module dspi_assembler
    import dspi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cs_active,
    input  logic              pri_s,
    input  logic              sec_s,
    input  logic              dual_s,
    output logic [WORD_W-1:0] data_o,
    output logic              vld_o,
    output logic              done_o,
    output logic              mode_o
);
    asm_state_t st_d, st_q;
    logic [WORD_W-1:0] shift_nx;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  cnt_nx;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.done = 1'b0;
        step      = st_q.dual ? CNT_W'(2) : CNT_W'(1);
        cnt_nx    = st_q.cnt + step;
        if (st_q.dual) begin
            shift_nx = {st_q.shreg[WORD_W-3:0], pri_s, sec_s};
        end else begin
            shift_nx = {st_q.shreg[WORD_W-2:0], pri_s};
        end

        if (cs_rise) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
            st_d.done  = 1'b1;
        end else if (cs_fall) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
            st_d.dual  = dual_s;
        end else if (cs_active && sclk_rise) begin
            st_d.shreg = shift_nx;
            if (cnt_nx == CNT_W'(WORD_W)) begin
                st_d.cnt  = '0;
                st_d.data = shift_nx;
                st_d.vld  = 1'b1;
            end else begin
                st_d.cnt = cnt_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign vld_o  = st_q.vld;
    assign done_o = st_q.done;
    assign mode_o = st_q.dual;
endmodule

// File: rtl/dspi_cmd_rx.sv
module dspi_cmd_rx
    import dspi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              pri_i,
    input  logic              sec_i,
    input  logic              dual_i,
    output logic [WORD_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              cmd_end_o
);
    localparam int unsigned PIN_N = 5;

    logic [PIN_N-1:0] pins_async;
    logic [PIN_N-1:0] pins_s;
    logic sclk_rise, cs_fall, cs_rise, cs_active;
    logic mode_q;

    assign pins_async = {dual_i, sec_i, pri_i, csn_i, sclk_i};

    dspi_sync #(
        .N_BITS (PIN_N),
        .STAGES (2),
        .RST_VAL(5'b00010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_async),
        .sync_o (pins_s)
    );

    dspi_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .csn_s    (pins_s[1]),
        .sclk_rise(sclk_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .cs_active(cs_active)
    );

    dspi_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .cs_active(cs_active),
        .pri_s    (pins_s[2]),
        .sec_s    (pins_s[3]),
        .dual_s   (pins_s[4]),
        .data_o   (byte_o),
        .vld_o    (byte_vld_o),
        .done_o   (cmd_end_o),
        .mode_o   (mode_q)
    );
endmodule

// File: rtl/dspi_cmd_rx_checker.sv
module dspi_cmd_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] byte_o,
    input logic       byte_vld_o,
    input logic       cmd_end_o,
    input logic       cs_active,
    input logic       cs_fall,
    input logic       mode_q
);
    // R8: strobe lasts one cycle
    a_r8_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R8: data moves only with a strobe
    a_r8_byte_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_o |-> $stable(byte_o));

    // R9: end pulse lasts one cycle
    a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_end_o |=> !cmd_end_o);

    // R6: no partial byte is reported at release
    a_r6_no_vld_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_end_o |-> !byte_vld_o);

    // R11: a byte needs chip select asserted the cycle before
    a_r11_vld_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(cs_active));

    // R7: mode changes only at chip-select assertion
    a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_fall) |-> $stable(mode_q));
endmodule

bind dspi_cmd_rx dspi_cmd_rx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_o    (byte_o),
    .byte_vld_o(byte_vld_o),
    .cmd_end_o (cmd_end_o),
    .cs_active (cs_active),
    .cs_fall   (cs_fall),
    .mode_q    (mode_q)
);

// File: tb/dspi_cmd_rx_tb.sv
module dspi_cmd_rx_tb;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0, csn_i = 1'b1, pri_i = 1'b0, sec_i = 1'b0, dual_i = 1'b0;
    logic [7:0] byte_o;
    logic byte_vld_o, cmd_end_o;

    int checks = 0, errors = 0;
    logic [7:0] got [64];
    int ng = 0, nend = 0, wide_vld = 0, wide_end = 0;
    logic prev_vld = 1'b0, prev_end = 1'b0;

    always #5 clk = ~clk;

    dspi_cmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i),
        .pri_i(pri_i), .sec_i(sec_i), .dual_i(dual_i),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o), .cmd_end_o(cmd_end_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld_o) begin
                if (ng < 64) got[ng] = byte_o;
                ng++;
                if (prev_vld) wide_vld++;
            end
            if (cmd_end_o) begin
                nend++;
                if (prev_end) wide_end++;
            end
            prev_vld = byte_vld_o;
            prev_end = cmd_end_o;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on(input logic mode);
        dual_i = mode;
        csn_i = 1'b0;
        wait_n(8);
    endtask

    task automatic cs_off();
        csn_i = 1'b1;
        wait_n(8);
    endtask

    task automatic clk_bits(input logic a, input logic b);
        pri_i = a; sec_i = b; sclk_i = 1'b0;
        wait_n(HALF);
        sclk_i = 1'b1;
        wait_n(HALF);
    endtask

    task automatic send_single(input logic [7:0] v, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) clk_bits(v[i], 1'b0);
        sclk_i = 1'b0;
        wait_n(HALF);
    endtask

    task automatic send_dual(input logic [7:0] v);
        for (int i = 3; i >= 0; i--) clk_bits(v[2*i+1], v[2*i]);
        sclk_i = 1'b0;
        wait_n(HALF);
    endtask

    task automatic t_reset();
        chk("R1 vld", byte_vld_o, 0);
        chk("R1 end", cmd_end_o, 0);
        chk("R1 byte", byte_o, 0);
    endtask

    task automatic t_single();
        int n0 = ng, e0 = nend;
        cs_on(1'b0);
        send_single(8'hA5, 8);
        send_single(8'h3C, 8);
        cs_off();
        chk("R2 count", ng - n0, 2);
        chk("R2 byte0", got[n0], 8'hA5);
        chk("R2 byte1", got[n0+1], 8'h3C);
        chk("R9 end count", nend - e0, 1);
    endtask

    task automatic t_dual();
        int n0 = ng;
        cs_on(1'b1);
        send_dual(8'h9C);
        send_dual(8'h63);
        cs_off();
        chk("R3 count", ng - n0, 2);
        chk("R4 R5 byte0", got[n0], 8'h9C);
        chk("R4 R5 byte1", got[n0+1], 8'h63);
    endtask

    task automatic t_partial();
        int n0 = ng, e0 = nend;
        cs_on(1'b0);
        send_single(8'hFF, 5);
        cs_off();
        chk("R6 no partial", ng - n0, 0);
        chk("R6 end", nend - e0, 1);
        cs_on(1'b0);
        send_single(8'h81, 8);
        cs_off();
        chk("R6 fresh count", ng - n0, 1);
        chk("R6 fresh byte", got[n0], 8'h81);
    endtask

    task automatic t_mode_hold();
        int n0 = ng;
        cs_on(1'b1);
        dual_i = 1'b0;
        wait_n(6);
        send_dual(8'hD2);
        cs_off();
        chk("R7 count", ng - n0, 1);
        chk("R7 byte", got[n0], 8'hD2);
    endtask

    task automatic t_idle_clock();
        int n0 = ng;
        pri_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk_i = 1'b1; wait_n(HALF);
            sclk_i = 1'b0; wait_n(HALF);
        end
        chk("R11 no byte idle", ng - n0, 0);
        cs_on(1'b0);
        send_single(8'h00, 8);
        cs_off();
        chk("R11 count", ng - n0, 1);
        chk("R11 byte", got[n0], 8'h00);
    endtask

    task automatic t_latency();
        cs_on(1'b0);
        send_single(8'h5A, 7);
        pri_i = 1'b0;
        wait_n(HALF);
        sclk_i = 1'b1;
        wait_n(2);
        chk("R10 early", byte_vld_o, 0);
        wait_n(1);
        chk("R10 due", byte_vld_o, 1);
        chk("R10 data", byte_o, 8'h5A);
        wait_n(HALF);
        sclk_i = 1'b0;
        wait_n(HALF);
        cs_off();
    endtask

    initial begin
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_single();
        t_dual();
        t_partial();
        t_mode_hold();
        t_idle_clock();
        t_latency();
        chk("R8 strobe width", wide_vld, 0);
        chk("R9 end width", wide_end, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule